// File: doc/BRIEF.md
# Power-Partition Toggle Sequencer

This block switches a single power partition on or off for software. A write to the command address carries a partition index, the wanted power state and a start flag. The sequencer sends a one-cycle toggle pulse with that index to the power switch. It then watches that partition's bit in the incoming status bitmap. If the bit does not reach the wanted state within a short polling window, the sequencer toggles again. After a bounded number of attempts it gives up and reports a busy result. Partitions marked as CPU partitions get one toggle and finish at once, with no polling.

The polling runs on a microsecond tick taken from a prescaler of the system clock. A second address removes the isolation clamp of one partition. The clamp index is mapped to a mask bit, and the PCIe and video-decode positions are exchanged in that mapping. Each command ends with a one-cycle done pulse and a 2-bit result code.

Top module: `pg_toggle_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, toggle_o and clamp_clr_o are all low or zero.
- R2: An operation starts only on a write to address 0x30 with data bit 8 set. Bit 9 is the wanted state (1 = on) and bits [4:0] are the partition index. A write to 0x30 with bit 8 clear, or a write to the status address 0x38, has no effect.
- R3: An index at or above NUM_PART (default 14) ends with done_o one cycle after the write, result 2 (invalid), and no toggle.
- R4: If the partition's status bit already equals the wanted state, done_o comes one cycle after the write with result 0 (ok), and no toggle is sent.
- R5: A partition flagged in CPU_MASK (default bits 0, 9, 10 and 11) gets exactly one toggle. done_o with result 0 comes in the same cycle, whatever the status does afterwards.
- R6: Otherwise one toggle is sent with toggle_idx_o equal to the index. The status bit is sampled on every tick. When it matches the wanted state, the operation ends with result 0.
- R7: If POLL_TICKS ticks (default 10) pass without a match, the toggle is sent again. After MAX_TRIES toggles (default 100) and a final window with no match, the result is 1 (busy).
- R8: busy_o is high while status is being polled. A command written while busy_o is high is ignored.
- R9: A write to 0x34 with an index in range drives clamp_clr_o for one cycle, starting the cycle after the write, with one bit set. That bit is the index's own bit, except that index 3 (PCIe) sets bit 4 and index 4 (video decode) sets bit 3. An out-of-range index drives nothing. Clamp writes are accepted even while busy_o is high.
- R10: done_o is a single-cycle pulse. result_o holds the code of the last operation: 0 ok, 1 busy, 2 invalid.
- R11: Ticks come every TICK_DIV clock cycles. An operation that never succeeds therefore lasts about MAX_TRIES × POLL_TICKS × TICK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 32 | Register write data |
| pwr_status_i | input | 16 | Power state of each partition, 1 = on |
| toggle_o | output | 1 | One-cycle toggle request to the power switch |
| toggle_idx_o | output | 5 | Partition index for the toggle request |
| clamp_clr_o | output | 16 | One-cycle clamp removal mask |
| busy_o | output | 1 | Status polling is in progress |
| done_o | output | 1 | Operation finished (pulse) |
| result_o | output | 2 | Result code of the last operation |

## Verification
Assertions check on every cycle that done_o never lasts two cycles, that the clamp mask has at most one bit set, and that no toggle goes with an invalid result. They also check that toggles appear only while polling or in the same cycle as done_o, and that the poll and attempt counters stay within their bounds. Only the bench scenarios can show the rest. This includes the exact number of toggles for a given amount of switch contention and the boundary between 100 attempts ending ok and ending busy. It also covers the swapped clamp mapping over every index, the one-toggle behaviour of CPU partitions, the ignoring of commands while busy, and the total duration of a failed operation.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_OK      = 2'd0,
    PG_BUSY    = 2'd1,
    PG_INVALID = 2'd2
  } pg_res_e;

  localparam logic [7:0] ADDR_CMD   = 8'h30;
  localparam logic [7:0] ADDR_CLAMP = 8'h34;
  localparam int START_BIT = 8;
  localparam int WANT_BIT  = 9;
  localparam int IDX_W     = 5;
  localparam int MAP_W     = 16;
endpackage

// File: rtl/pg_tick_gen.sv
module pg_tick_gen #(
  parameter int DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R11: DIV >= 2 gives isolated ticks
  a_r11_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pg_clamp_map.sv
module pg_clamp_map #(
  parameter int NUM_PART = 14,
  parameter int PCIE_IDX = 3,
  parameter int VDEC_IDX = 4,
  parameter int W        = 16,
  parameter int IW       = 5
) (
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  mask_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    localparam int SRC = (g == PCIE_IDX) ? VDEC_IDX :
                         (g == VDEC_IDX) ? PCIE_IDX : g;
    if (g < NUM_PART) begin : g_live
      assign mask_o[g] = (idx_i == IW'(SRC));
    end else begin : g_dead
      assign mask_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/pg_seq.sv
module pg_seq
  import pg_pkg::*;
#(
  parameter int             NUM_PART   = 14,
  parameter logic [MAP_W-1:0] CPU_MASK = 16'h0E01,
  parameter int             POLL_TICKS = 10,
  parameter int             MAX_TRIES  = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             want_i,
  input  logic             tick_i,
  input  logic [MAP_W-1:0] status_i,
  output logic             toggle_o,
  output logic [IDX_W-1:0] toggle_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output pg_res_e          result_o
);
  localparam int SW = $clog2(MAP_W);
  localparam int PW = $clog2(POLL_TICKS + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e st_q;
  logic [IDX_W-1:0] idx_q;
  logic want_q;
  logic [PW-1:0] poll_q;
  logic [TW-1:0] try_q;

  logic in_range, cur_in, cur_q, is_cpu;
  assign in_range = idx_i < IDX_W'(NUM_PART);
  assign cur_in   = status_i[idx_i[SW-1:0]];
  assign is_cpu   = CPU_MASK[idx_i[SW-1:0]];
  assign cur_q    = status_i[idx_q[SW-1:0]];

  assign toggle_idx_o = idx_q;
  assign busy_o       = (st_q == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      want_q   <= 1'b0;
      poll_q   <= '0;
      try_q    <= '0;
      toggle_o <= 1'b0;
      done_o   <= 1'b0;
      result_o <= PG_OK;
    end else begin
      toggle_o <= 1'b0;
      done_o   <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          idx_q  <= idx_i;
          want_q <= want_i;
          poll_q <= '0;
          try_q  <= '0;
          if (!in_range) begin
            done_o   <= 1'b1;
            result_o <= PG_INVALID;
          end else if (cur_in == want_i) begin
            done_o   <= 1'b1;
            result_o <= PG_OK;
          end else if (is_cpu) begin
            toggle_o <= 1'b1;
            done_o   <= 1'b1;
            result_o <= PG_OK;
          end else begin
            toggle_o <= 1'b1;
            st_q     <= ST_WAIT;
          end
        end
        ST_WAIT: if (tick_i) begin
          if (cur_q == want_q) begin
            done_o   <= 1'b1;
            result_o <= PG_OK;
            st_q     <= ST_IDLE;
          end else if (poll_q == PW'(POLL_TICKS - 1)) begin
            poll_q <= '0;
            if (try_q == TW'(MAX_TRIES - 1)) begin
              done_o   <= 1'b1;
              result_o <= PG_BUSY;
              st_q     <= ST_IDLE;
            end else begin
              toggle_o <= 1'b1;
              try_q    <= try_q + 1'b1;
            end
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_invalid_no_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o == PG_INVALID) |-> !toggle_o);
  a_r8_toggle_context: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_o |-> (busy_o || done_o));
  a_r6_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PW'(POLL_TICKS));
  a_r7_try_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    try_q < TW'(MAX_TRIES));
  a_r7_busy_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o == PG_BUSY) |-> $past(busy_o));
endmodule

// File: rtl/pg_toggle_ctrl.sv
module pg_toggle_ctrl
  import pg_pkg::*;
#(
  parameter int               NUM_PART   = 14,
  parameter logic [MAP_W-1:0] CPU_MASK   = 16'h0E01,
  parameter int               PCIE_IDX   = 3,
  parameter int               VDEC_IDX   = 4,
  parameter int               TICK_DIV   = 125,
  parameter int               POLL_TICKS = 10,
  parameter int               MAX_TRIES  = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_addr_i,
  input  logic [31:0]      wr_data_i,
  input  logic [MAP_W-1:0] pwr_status_i,
  output logic             toggle_o,
  output logic [IDX_W-1:0] toggle_idx_o,
  output logic [MAP_W-1:0] clamp_clr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o
);
  logic cmd_start, clamp_wr, tick;
  logic [MAP_W-1:0] clamp_mask;
  pg_res_e res;
  logic unused_data;

  assign unused_data = ^{wr_data_i[31:WANT_BIT+1], wr_data_i[START_BIT-1:IDX_W]};
  assign cmd_start = wr_en_i && (wr_addr_i == ADDR_CMD) && wr_data_i[START_BIT];
  assign clamp_wr  = wr_en_i && (wr_addr_i == ADDR_CLAMP);
  assign result_o  = res;

  pg_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  pg_clamp_map #(
    .NUM_PART(NUM_PART), .PCIE_IDX(PCIE_IDX), .VDEC_IDX(VDEC_IDX),
    .W(MAP_W), .IW(IDX_W)
  ) u_clamp (
    .idx_i(wr_data_i[IDX_W-1:0]), .mask_o(clamp_mask)
  );

  pg_seq #(
    .NUM_PART(NUM_PART), .CPU_MASK(CPU_MASK),
    .POLL_TICKS(POLL_TICKS), .MAX_TRIES(MAX_TRIES)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i(cmd_start),
    .idx_i(wr_data_i[IDX_W-1:0]),
    .want_i(wr_data_i[WANT_BIT]),
    .tick_i(tick),
    .status_i(pwr_status_i),
    .toggle_o, .toggle_idx_o, .busy_o, .done_o,
    .result_o(res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clamp_clr_o <= '0;
    else         clamp_clr_o <= clamp_wr ? clamp_mask : '0;
  end

  a_r9_clamp_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clamp_clr_o));
  a_r9_clamp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_clr_o != '0) |-> $past(clamp_wr));
endmodule

// File: tb/tb_pg_toggle_ctrl.sv
module tb_pg_toggle_ctrl;
  localparam int TD = 4;
  localparam int NP = 14;
  localparam logic [15:0] CPUM = 16'h0E01;
  localparam int RESP_DLY = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [15:0] pstat = '0;
  logic toggle_o, busy_o, done_o;
  logic [4:0] toggle_idx_o;
  logic [15:0] clamp_clr_o;
  logic [1:0] result_o;

  always #4 clk_i = ~clk_i;

  pg_toggle_ctrl #(.NUM_PART(NP), .CPU_MASK(CPUM), .TICK_DIV(TD)) dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .pwr_status_i(pstat), .toggle_o, .toggle_idx_o, .clamp_clr_o,
    .busy_o, .done_o, .result_o
  );

  // power switch model: ignores the first ignore_n toggles, then flips after RESP_DLY
  int ignore_n [16];
  int tog_per [32];
  int tog_total = 0;
  bit stuck = 1'b0;
  logic [15:0] pend = '0;
  int cnt [16];

  initial for (int i = 0; i < 16; i++) begin ignore_n[i] = 0; cnt[i] = 0; end
  initial for (int i = 0; i < 32; i++) tog_per[i] = 0;

  always @(posedge clk_i) begin
    for (int i = 0; i < 16; i++)
      if (pend[i]) begin
        if (cnt[i] == 0) begin pstat[i] <= ~pstat[i]; pend[i] <= 1'b0; end
        else cnt[i] <= cnt[i] - 1;
      end
    if (toggle_o) begin
      tog_total++;
      tog_per[toggle_idx_o]++;
      if (!stuck) begin
        if (ignore_n[toggle_idx_o[3:0]] > 0) ignore_n[toggle_idx_o[3:0]]--;
        else begin pend[toggle_idx_o[3:0]] <= 1'b1; cnt[toggle_idx_o[3:0]] <= RESP_DLY - 1; end
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  // issue command, wait for done; lat counts negedges after the write edge
  task automatic cmd(input int idx, input bit want, output int res, output int lat);
    wr(8'h30, (32'(want) << 9) | 32'h100 | 32'(idx));
    lat = 1;
    while (!done_o && lat < 20000) begin @(negedge clk_i); lat++; end
    res = int'(result_o);
  endtask

  int res, lat, t0;
  logic [15:0] exp_m;

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && toggle_o == 0 && clamp_clr_o == 0, "R1 reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && clamp_clr_o == 0, "R1 after release", int'(done_o), 0);

    // R3 out of range indices
    foreach (exp_m[k]) ;
    for (int idx = NP; idx < 32; idx += 3) begin
      t0 = tog_total;
      cmd(idx, 1'b1, res, lat);
      chk(res == 2 && lat == 1, "R3 invalid result", res, 2);
      chk(tog_total == t0, "R3 no toggle", tog_total - t0, 0);
    end

    // R4 already matching (all off, want off)
    for (int idx = 0; idx < NP; idx++) begin
      t0 = tog_total;
      cmd(idx, 1'b0, res, lat);
      chk(res == 0 && lat == 1 && tog_total == t0, "R4 match no toggle", tog_total - t0, 0);
    end
    @(negedge clk_i);
    chk(done_o == 0, "R10 done single cycle", int'(done_o), 0);

    // R6 sweep of non-cpu partitions, on then off
    for (int idx = 0; idx < NP; idx++) begin
      if (!CPUM[idx]) begin
        t0 = tog_per[idx];
        cmd(idx, 1'b1, res, lat);
        chk(res == 0 && tog_per[idx] == t0 + 1 && pstat[idx], "R6 power on", tog_per[idx] - t0, 1);
        cmd(idx, 1'b0, res, lat);
        chk(res == 0 && tog_per[idx] == t0 + 2 && !pstat[idx], "R6 power off", tog_per[idx] - t0, 2);
      end
    end

    // R5 cpu partitions: switch never answers
    stuck = 1'b1;
    for (int idx = 0; idx < NP; idx++) begin
      if (CPUM[idx]) begin
        t0 = tog_per[idx];
        cmd(idx, 1'b1, res, lat);
        chk(res == 0 && lat == 1, "R5 cpu immediate ok", lat, 1);
        repeat (5) @(negedge clk_i);
        chk(tog_per[idx] == t0 + 1 && busy_o == 0, "R5 cpu single toggle", tog_per[idx] - t0, 1);
      end
    end

    // R11 / R7: never succeeds -> busy after full duration
    t0 = tog_per[6];
    cmd(6, 1'b1, res, lat);
    chk(res == 1, "R7 busy result", res, 1);
    chk(tog_per[6] - t0 == 100, "R7 toggle count at failure", tog_per[6] - t0, 100);
    chk(lat >= 1000 * TD - TD && lat <= 1000 * TD + TD + 2, "R11 failure duration", lat, 1000 * TD);
    stuck = 1'b0;

    // R7 contention depths
    ignore_n[6] = 3; t0 = tog_per[6];
    cmd(6, 1'b1, res, lat);
    chk(res == 0 && tog_per[6] - t0 == 4, "R7 retry after 3 ignored", tog_per[6] - t0, 4);
    ignore_n[6] = 99; t0 = tog_per[6];
    cmd(6, 1'b0, res, lat);
    chk(res == 0 && tog_per[6] - t0 == 100, "R7 success on last attempt", tog_per[6] - t0, 100);
    ignore_n[6] = 100; t0 = tog_per[6];
    cmd(6, 1'b1, res, lat);
    chk(res == 1 && tog_per[6] - t0 == 100, "R7 busy after 100 attempts", res, 1);
    ignore_n[6] = 0;
    chk(pstat[6] == 1'b0, "R7 state unchanged after busy", int'(pstat[6]), 0);

    // R8 commands ignored while busy
    ignore_n[5] = 5; t0 = tog_per[7];
    wr(8'h30, 32'h300 | 32'd5);
    chk(busy_o == 1, "R8 busy during poll", int'(busy_o), 1);
    wr(8'h30, 32'h300 | 32'd7);
    lat = 0;
    while (!done_o && lat < 20000) begin @(negedge clk_i); lat++; end
    chk(result_o == 0 && pstat[5], "R8 first op completes", int'(result_o), 0);
    repeat (10) @(negedge clk_i);
    chk(tog_per[7] == t0 && !pstat[7], "R8 second command ignored", tog_per[7] - t0, 0);

    // R2 writes without effect
    t0 = tog_total;
    wr(8'h30, 32'h200 | 32'd8);
    repeat (3) @(negedge clk_i);
    chk(tog_total == t0 && !done_o && !busy_o, "R2 no start bit", tog_total - t0, 0);
    wr(8'h38, 32'h300 | 32'd8);
    repeat (3) @(negedge clk_i);
    chk(tog_total == t0 && !pstat[8], "R2 status address write", tog_total - t0, 0);

    // R9 clamp sweep, also while busy
    for (int idx = 0; idx < 32; idx++) begin
      exp_m = (idx >= NP) ? 16'h0 : (idx == 3) ? 16'h0010 : (idx == 4) ? 16'h0008 : 16'(1 << idx);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = 8'h34; wr_data_i = 32'(idx);
      @(negedge clk_i);
      wr_en_i = 1'b0;
      chk(clamp_clr_o == exp_m, "R9 clamp mask", int'(clamp_clr_o), int'(exp_m));
      @(negedge clk_i);
      chk(clamp_clr_o == 0, "R9 clamp one cycle", int'(clamp_clr_o), 0);
    end
    ignore_n[2] = 2;
    wr(8'h30, 32'h300 | 32'd2);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 8'h34; wr_data_i = 32'd4;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk(clamp_clr_o == 16'h0008 && busy_o, "R9 clamp while busy", int'(clamp_clr_o), 8);
    lat = 0;
    while (!done_o && lat < 20000) begin @(negedge clk_i); lat++; end
    chk(result_o == 0, "R10 result ok code", int'(result_o), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule